// File: doc/BRIEF.md
# Far-End Block Error Transmit Control

This block chooses the value of the far-end block error bit (febe) that goes into each outgoing superframe of a digital subscriber line transceiver. The bit is active-low: 0 tells the far end that a block error was seen, and 1 means no error. Three sources can pull it low, and each has its own gate:

- A CRC mismatch found in the superframe just received, gated by a local-force enable.
- A request bit written by software, gated by a remote-force enable.
- A permanent-force control that works on its own.

The decision is taken at each superframe boundary. It is held for the whole superframe that follows.

An external checker reports the CRC result with a valid strobe, at any time within a superframe. The result is held until the next boundary and then used or dropped. When a software request has been sent for one superframe, the request bit returns to 1 by itself, and a one-cycle indication is raised. Framing, line coding, CRC computation and the register bus are outside this block.

Top module: `febe_tx_ctrl`

## Requirements
- R1: After reset, febe_o is 1, req_bit_o is 1, req_clr_o is 0 and no CRC mismatch is pending.
- R2: febe_o changes only in the cycle that follows a clock edge at which sf_strobe_i is 1. It is held for the rest of the superframe.
- R3: A mismatch (crc_vld_i=1 with crc_ok_i=0) may arrive at any cycle of a superframe, including the boundary cycle itself. If it does and loc_force_en_i is 1 at the boundary, febe_o is 0 for the next superframe.
- R4: Every boundary discards the pending mismatch. A mismatch at a boundary where loc_force_en_i is 0 has no effect on that superframe or on any later one.
- R5: perm_n_i=0 at a boundary gives febe_o=0 for the next superframe, whatever the other inputs are.
- R6: req_bit_o=0 with rem_force_en_i=1 at a boundary gives febe_o=0 for exactly one superframe. With rem_force_en_i=0 the request has no effect, and req_bit_o stays 0.
- R7: At the boundary that ends the superframe carrying a request, req_bit_o returns to 1. req_clr_o is 1 for that one cycle.
- R8: req_wr_i=1 loads req_wdata_i into req_bit_o on the next cycle. A write cancels a pending automatic return, and it takes priority over a boundary in the same cycle.
- R9: The sources combine with a logical AND on the active-low bit. Any single active source gives febe_o=0. When no source is active, febe_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sf_strobe_i | input | 1 | One-cycle superframe boundary strobe |
| crc_vld_i | input | 1 | CRC comparison result is valid this cycle |
| crc_ok_i | input | 1 | Received CRC matched the local CRC (1) or not (0) |
| req_wr_i | input | 1 | Write strobe for the request bit |
| req_wdata_i | input | 1 | Value written to the request bit (0 requests an error report) |
| rem_force_en_i | input | 1 | Enables the software request as a source |
| loc_force_en_i | input | 1 | Enables a CRC mismatch as a source |
| perm_n_i | input | 1 | 0 forces febe to 0 in every superframe |
| febe_o | output | 1 | febe bit for the current outgoing superframe |
| req_bit_o | output | 1 | Current value of the request bit |
| req_clr_o | output | 1 | One-cycle pulse when the request bit returns to 1 by itself |

## Verification
Directed cases drive each source alone, with its enable set and then with it cleared. A low febe_o can therefore be traced to one source, and a disabled source can be seen to be ignored. Further directed cases cover three points:

- A mismatch that arrives in the boundary cycle itself, which separates same-cycle capture from capture one superframe late.
- A mismatch under a cleared enable followed by an enabled boundary, which separates discarding from carrying the mismatch forward.
- A write that coincides with the boundary, which shows whether the write or the automatic return wins.

Random sequences with irregular superframe lengths and overlapping sources then check the combination and the one-superframe lifetime of a request.

// File: rtl/febe_pkg.sv
package febe_pkg;
  typedef struct packed {
    logic perm;
    logic crc;
    logic remote;
  } febe_force_t;

  localparam int unsigned NUM_SRC = $bits(febe_force_t);

  // active-low febe: any asserted source yields 0
  function automatic logic febe_resolve(input febe_force_t f);
    return ~(|f);
  endfunction
endpackage

// File: rtl/febe_crc_track.sv
module febe_crc_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sf_strobe_i,
  input  logic crc_vld_i,
  input  logic crc_ok_i,
  output logic mism_o
);
  logic pend_q;

  // include a mismatch reported in the boundary cycle itself
  assign mism_o = pend_q | (crc_vld_i & ~crc_ok_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (sf_strobe_i) pend_q <= 1'b0;
    else                  pend_q <= mism_o;
  end
endmodule

// File: rtl/febe_req_reg.sv
module febe_req_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sf_strobe_i,
  input  logic rem_en_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic req_o,
  output logic force_o,
  output logic clr_o
);
  logic req_q, armed_q, clr_q;

  // request active only until it has been latched once
  assign force_o = ~req_q & ~armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b1;
      armed_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= sf_strobe_i & armed_q & ~wr_i;
      if (wr_i) begin
        req_q   <= wdata_i;
        armed_q <= 1'b0;
      end else if (sf_strobe_i) begin
        if (armed_q) begin
          req_q   <= 1'b1;
          armed_q <= 1'b0;
        end else if (rem_en_i && force_o) begin
          armed_q <= 1'b1;
        end
      end
    end
  end

  assign req_o = req_q;
  assign clr_o = clr_q;
endmodule

// File: rtl/febe_out_reg.sv
module febe_out_reg
  import febe_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sf_strobe_i,
  input  febe_force_t force_i,
  output logic        febe_o
);
  logic febe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          febe_q <= 1'b1;
    else if (sf_strobe_i) febe_q <= febe_resolve(force_i);
  end

  assign febe_o = febe_q;
endmodule

// File: rtl/febe_tx_ctrl.sv
module febe_tx_ctrl
  import febe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sf_strobe_i,
  input  logic crc_vld_i,
  input  logic crc_ok_i,
  input  logic req_wr_i,
  input  logic req_wdata_i,
  input  logic rem_force_en_i,
  input  logic loc_force_en_i,
  input  logic perm_n_i,
  output logic febe_o,
  output logic req_bit_o,
  output logic req_clr_o
);
  logic        mism;
  logic        req_force;
  febe_force_t srcs;

  febe_crc_track u_crc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sf_strobe_i (sf_strobe_i),
    .crc_vld_i   (crc_vld_i),
    .crc_ok_i    (crc_ok_i),
    .mism_o      (mism)
  );

  febe_req_reg u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sf_strobe_i (sf_strobe_i),
    .rem_en_i    (rem_force_en_i),
    .wr_i        (req_wr_i),
    .wdata_i     (req_wdata_i),
    .req_o       (req_bit_o),
    .force_o     (req_force),
    .clr_o       (req_clr_o)
  );

  always_comb begin
    srcs.perm   = ~perm_n_i;
    srcs.crc    = loc_force_en_i & mism;
    srcs.remote = rem_force_en_i & req_force;
  end

  febe_out_reg u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sf_strobe_i (sf_strobe_i),
    .force_i     (srcs),
    .febe_o      (febe_o)
  );
endmodule

// File: rtl/febe_tx_ctrl_chk.sv
module febe_tx_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sf_strobe_i,
  input logic crc_vld_i,
  input logic crc_ok_i,
  input logic req_wr_i,
  input logic req_wdata_i,
  input logic rem_force_en_i,
  input logic loc_force_en_i,
  input logic perm_n_i,
  input logic febe_o,
  input logic req_bit_o,
  input logic req_clr_o
);
  a_r2_hold_between_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sf_strobe_i |=> $stable(febe_o));

  a_r3_crc_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_strobe_i && loc_force_en_i && crc_vld_i && !crc_ok_i) |=> !febe_o);

  a_r5_perm_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_strobe_i && !perm_n_i) |=> !febe_o);

  a_r7_clr_sets_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_clr_o |-> (req_bit_o && $past(sf_strobe_i)));

  a_r8_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_wr_i |=> (req_bit_o == $past(req_wdata_i)));

  a_r9_no_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_strobe_i && perm_n_i && !loc_force_en_i && !rem_force_en_i) |=> febe_o);
endmodule

bind febe_tx_ctrl febe_tx_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sf_strobe_i    (sf_strobe_i),
  .crc_vld_i      (crc_vld_i),
  .crc_ok_i       (crc_ok_i),
  .req_wr_i       (req_wr_i),
  .req_wdata_i    (req_wdata_i),
  .rem_force_en_i (rem_force_en_i),
  .loc_force_en_i (loc_force_en_i),
  .perm_n_i       (perm_n_i),
  .febe_o         (febe_o),
  .req_bit_o      (req_bit_o),
  .req_clr_o      (req_clr_o)
);

// File: tb/febe_tx_ctrl_tb.sv
module febe_tx_ctrl_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sf_strobe_i = 0, crc_vld_i = 0, crc_ok_i = 1, req_wr_i = 0, req_wdata_i = 1;
  logic rem_force_en_i = 0, loc_force_en_i = 0, perm_n_i = 1;
  logic febe_o, req_bit_o, req_clr_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic m_req = 1, m_armed = 0, m_pend = 0, m_febe = 1, m_clr = 0;

  always #5 clk_i = ~clk_i;

  febe_tx_ctrl u_dut (.*);

  function automatic logic exp_febe(logic perm_n, logic loc, logic pend, logic rem,
                                    logic req, logic armed);
    return !(!perm_n || (loc && pend) || (rem && !req && !armed));
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: inputs already driven; update model at edge, check after it
  task automatic step(string tag);
    logic pend_d;
    @(posedge clk_i);
    pend_d = m_pend | (crc_vld_i & ~crc_ok_i);
    m_clr  = sf_strobe_i & m_armed & ~req_wr_i;
    if (sf_strobe_i) begin
      m_febe = exp_febe(perm_n_i, loc_force_en_i, pend_d, rem_force_en_i, m_req, m_armed);
      m_pend = 1'b0;
    end else m_pend = pend_d;
    if (req_wr_i) begin
      m_req = req_wdata_i; m_armed = 1'b0;
    end else if (sf_strobe_i) begin
      if (m_armed) begin m_req = 1'b1; m_armed = 1'b0; end
      else if (rem_force_en_i && !m_req) m_armed = 1'b1;
    end
    #1;
    chk({tag, " febe"}, febe_o, m_febe);
    chk({tag, " req"}, req_bit_o, m_req);
    chk({tag, " clr"}, req_clr_o, m_clr);
    @(negedge clk_i);
    sf_strobe_i = 0; crc_vld_i = 0; crc_ok_i = 1; req_wr_i = 0;
  endtask

  task automatic bound(string tag);
    sf_strobe_i = 1; step(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    // R1 reset state
    chk("R1 febe", febe_o, 1'b1);
    chk("R1 req", req_bit_o, 1'b1);
    chk("R1 clr", req_clr_o, 1'b0);
    @(negedge clk_i); rst_ni = 1;
    idle(2, "R1");
    bound("R1");
    chk("R1 no pending mismatch", febe_o, 1'b1);

    // R5 permanent force, R2 hold mid-superframe
    perm_n_i = 0; idle(2, "R2"); chk("R2 no change before boundary", febe_o, 1'b1);
    bound("R5"); chk("R5 perm", febe_o, 1'b0);
    perm_n_i = 1; idle(3, "R2"); chk("R2 held", febe_o, 1'b0);
    bound("R9"); chk("R9 no source", febe_o, 1'b1);

    // R3 mismatch mid-superframe, then in boundary cycle
    loc_force_en_i = 1;
    crc_vld_i = 1; crc_ok_i = 0; step("R3"); idle(2, "R3");
    bound("R3"); chk("R3 mid mismatch", febe_o, 1'b0);
    idle(2, "R3"); bound("R3"); chk("R3 cleared", febe_o, 1'b1);
    crc_vld_i = 1; crc_ok_i = 0; bound("R3"); chk("R3 boundary mismatch", febe_o, 1'b0);
    // R4 discarded when disabled
    loc_force_en_i = 0; idle(1, "R4");
    crc_vld_i = 1; crc_ok_i = 0; step("R4"); bound("R4");
    chk("R4 ignored", febe_o, 1'b1);
    loc_force_en_i = 1; idle(2, "R4"); bound("R4"); chk("R4 discarded", febe_o, 1'b1);
    loc_force_en_i = 0;

    // R6/R7 request
    rem_force_en_i = 1;
    req_wr_i = 1; req_wdata_i = 0; step("R8"); chk("R8 write", req_bit_o, 1'b0);
    idle(2, "R6"); bound("R6"); chk("R6 request sent", febe_o, 1'b0);
    idle(3, "R6"); bound("R7"); chk("R7 auto return", req_bit_o, 1'b1);
    chk("R7 clr pulse", req_clr_o, 1'b1); chk("R6 one superframe", febe_o, 1'b1);
    idle(1, "R7"); chk("R7 clr single", req_clr_o, 1'b0);
    // disabled request
    rem_force_en_i = 0;
    req_wr_i = 1; req_wdata_i = 0; step("R6");
    bound("R6"); chk("R6 disabled", febe_o, 1'b1); chk("R6 req kept", req_bit_o, 1'b0);
    // R8 write coinciding with the return boundary
    rem_force_en_i = 1; bound("R8"); chk("R8 armed", febe_o, 1'b0);
    idle(2, "R8"); req_wr_i = 1; req_wdata_i = 0; bound("R8");
    chk("R8 write wins", req_bit_o, 1'b0); chk("R8 no clr", req_clr_o, 1'b0);
    bound("R9"); chk("R9 re-request", febe_o, 1'b0);
    req_wr_i = 1; req_wdata_i = 1; step("R8");

    // random mix
    for (int sf = 0; sf < 1500; sf++) begin
      int len = 1 + ($urandom % 9);
      perm_n_i       = ($urandom % 6) != 0;
      loc_force_en_i = $urandom % 2;
      rem_force_en_i = $urandom % 2;
      for (int c = 0; c < len; c++) begin
        crc_vld_i   = ($urandom % 5) == 0;
        crc_ok_i    = ($urandom % 3) != 0;
        req_wr_i    = ($urandom % 11) == 0;
        req_wdata_i = $urandom % 2;
        sf_strobe_i = (c == len - 1);
        step("R9");
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule